// File: doc/BRIEF.md
# Seven-Input Stacking Counter with Carry Select

This combinational block counts the ones among seven bits of equal weight and gives the result as a 3-bit binary number. It is meant as a compression cell inside a partial-product reduction tree. Its outputs have weights 1, 2 and 4.

The first six inputs are sorted into two 3-bit thermometer stacks. These are merged into one 6-bit thermometer stack `j`, whose bit k is high when more than k of `x_i[5:0]` are set. Both carry bits are computed twice from `j`. One pair assumes `x_i[6]` is low and the other assumes it is high. A 2:1 select driven by `x_i[6]` picks one pair. The carries therefore wait for one mux level and never for a chain of XOR gates. The weight-1 bit is the parity of the two stacks, with `x_i[6]` added by one more XOR.

Top module: `stack_cnt7`

## Requirements
- R1: Each 3-input stacker raises its output bit k exactly when more than k of its three inputs are one. The outputs of one stacker never show a one above a zero.
- R2: The merged stack `j` has bit k (k = 0..5) high exactly when more than k of `x_i[5:0]` are one.
- R3: `cnt_o[0]` equals the XOR of all seven bits of `x_i`.
- R4: With `x_i[6]` = 0, `cnt_o[2:1]` equals bits 2:1 of the count of ones in `x_i[5:0]`.
- R5: With `x_i[6]` = 1, `cnt_o[2]` is high exactly when at least three of `x_i[5:0]` are one. `cnt_o[1]` is high exactly when that count is 1, 2, 5 or 6.
- R6: For every one of the 128 input patterns, `cnt_o` read as an unsigned number equals the number of ones in `x_i`. Bit 0 has weight 1, bit 1 weight 2 and bit 2 weight 4.
- R7: An all-zero input gives `cnt_o` = 0, and an all-one input gives `cnt_o` = 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 7 | Seven bits of equal weight; bit 6 steers the carry select |
| cnt_o | output | 3 | Binary count of ones in `x_i` |

## Verification
Some cases are hard to reach because the two carry pairs are only visible through the select. The pair that assumes `x_i[6]` = 1 with a full six-bit stack (count 6), and the pairs near the boundary counts 2/3 and 4/5, show up at the output only when `x_i[6]` is set at the same time. The bench sweeps all 128 patterns, so each of the seven counts of `x_i[5:0]` is seen under both select values. Patterns that vary only one 3-bit group reach each stacker's thermometer outputs one at a time.

// File: rtl/stack_cnt7_pkg.sv
package stack_cnt7_pkg;
  localparam int unsigned GRP_W  = 3;
  localparam int unsigned HALF_N = 2;
  localparam int unsigned LOW_W  = GRP_W * HALF_N;
  localparam int unsigned IN_W   = LOW_W + 1;
  localparam int unsigned CNT_W  = $clog2(IN_W + 1);

  typedef logic [GRP_W-1:0] grp_stack_t;
  typedef logic [LOW_W-1:0] low_stack_t;

  typedef struct packed {
    logic c2;
    logic c1;
  } carry_pair_t;
endpackage

// File: rtl/stack3.sv
module stack3
  import stack_cnt7_pkg::*;
(
  input  logic [GRP_W-1:0] in_i,
  output grp_stack_t       stk_o
);
  assign stk_o[0] = in_i[0] | in_i[1] | in_i[2];
  assign stk_o[1] = (in_i[0] & in_i[1]) | (in_i[0] & in_i[2]) | (in_i[1] & in_i[2]);
  assign stk_o[2] = in_i[0] & in_i[1] & in_i[2];

  always_comb begin
    assert_stack3_thermo_R1: assert (!(stk_o[2] & ~stk_o[1]) && !(stk_o[1] & ~stk_o[0]))
      else $error("R1 stacker not thermometer");
    assert_stack3_count_R1: assert ($countones(stk_o) == $countones(in_i))
      else $error("R1 stacker height mismatch");
  end
endmodule

// File: rtl/stack_merge.sv
module stack_merge
  import stack_cnt7_pkg::*;
(
  input  grp_stack_t h_i,
  input  grp_stack_t i_i,
  output low_stack_t j_o
);
  // Extended stacks: index 0 is an implicit "height >= 0" one.
  logic [GRP_W:0] h_ext, i_ext;
  assign h_ext = {h_i, 1'b1};
  assign i_ext = {i_i, 1'b1};

  // j[k] set when some split a+b = k+1 has both stacks tall enough.
  always_comb begin
    j_o = '0;
    for (int k = 0; k < LOW_W; k++) begin
      for (int a = 0; a <= GRP_W; a++) begin
        if ((k + 1 - a) >= 0 && (k + 1 - a) <= GRP_W)
          j_o[k] = j_o[k] | (h_ext[a] & i_ext[k+1-a]);
      end
    end
  end

  always_comb begin
    assert_merge_height_R2: assert ($countones(j_o) == $countones(h_i) + $countones(i_i))
      else $error("R2 merged height mismatch");
    for (int k = 1; k < LOW_W; k++)
      assert_merge_thermo_R2: assert (!(j_o[k] & ~j_o[k-1]))
        else $error("R2 merged stack not thermometer");
  end
endmodule

// File: rtl/carry_select.sv
module carry_select
  import stack_cnt7_pkg::*;
(
  input  low_stack_t j_i,
  input  logic       sel_i,
  output carry_pair_t carry_o
);
  carry_pair_t pair_lo, pair_hi;

  // sel low: six-input weights 2/4 (counts 2,3,6 -> c1; >=4 -> c2)
  assign pair_lo.c1 = (j_i[1] & ~j_i[3]) | j_i[5];
  assign pair_lo.c2 = j_i[3];
  // sel high: count+1 (counts 1,2,5,6 -> c1; >=3 -> c2)
  assign pair_hi.c1 = (j_i[0] & ~j_i[2]) | j_i[4];
  assign pair_hi.c2 = j_i[0] & j_i[1] & j_i[2];

  assign carry_o = sel_i ? pair_hi : pair_lo;

  always_comb begin
    if (!sel_i) begin
      assert_sel_lo_R4: assert ({carry_o.c2, carry_o.c1} == 2'(($countones(j_i)) >> 1))
        else $error("R4 low carry pair wrong");
    end else begin
      assert_sel_hi_R5: assert ({carry_o.c2, carry_o.c1} == 2'(($countones(j_i) + 1) >> 1))
        else $error("R5 high carry pair wrong");
    end
  end
endmodule

// File: rtl/stack_cnt7.sv
module stack_cnt7
  import stack_cnt7_pkg::*;
(
  input  logic [IN_W-1:0]  x_i,
  output logic [CNT_W-1:0] cnt_o
);
  grp_stack_t  grp_stk [HALF_N];
  low_stack_t  j_stk;
  carry_pair_t carry;
  logic [HALF_N-1:0] grp_odd;
  logic        sum_bit;

  for (genvar g = 0; g < HALF_N; g++) begin : g_grp
    stack3 i_stack3 (
      .in_i  (x_i[g*GRP_W +: GRP_W]),
      .stk_o (grp_stk[g])
    );
    // odd height: exactly one or three ones
    assign grp_odd[g] = (grp_stk[g][0] & ~grp_stk[g][1]) | grp_stk[g][2];
  end

  stack_merge i_stack_merge (
    .h_i (grp_stk[0]),
    .i_i (grp_stk[1]),
    .j_o (j_stk)
  );

  carry_select i_carry_select (
    .j_i     (j_stk),
    .sel_i   (x_i[IN_W-1]),
    .carry_o (carry)
  );

  assign sum_bit = ^grp_odd ^ x_i[IN_W-1];
  assign cnt_o   = {carry.c2, carry.c1, sum_bit};

  always_comb begin
    assert_sum_parity_R3: assert (cnt_o[0] == ^x_i)
      else $error("R3 sum bit not parity");
    assert_total_count_R6: assert (32'(cnt_o) == $countones(x_i))
      else $error("R6 count mismatch");
  end
endmodule

// File: tb/test_stack_cnt7.sv
module test_stack_cnt7;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] x;
  logic [2:0] cnt;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cnt7 i_stack_cnt7 (.x_i(x), .cnt_o(cnt));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s x=%b actual=%0d expected=%0d", req, x, act, exp);
    end
  endtask

  function automatic int ones(input logic [6:0] v, input int w);
    int c = 0;
    for (int b = 0; b < w; b++) c += int'(v[b]);
    return c;
  endfunction

  task automatic apply(input logic [6:0] v);
    @(negedge clk);
    x = v;
    #1;
  endtask

  initial begin
    x = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R7 corners
    apply(7'h00); check("R7 zero", int'(cnt), 0);
    apply(7'h7f); check("R7 ones", int'(cnt), 7);
    // R1: one stacker at a time, other inputs quiet
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 8; p++) begin
        apply(7'(p << (3*g)));
        check("R1 group", int'(cnt), ones(7'(p), 3));
      end
    // R2: every low-six pattern with x6 low
    for (int p = 0; p < 64; p++) begin
      apply(7'(p));
      check("R2 merge", int'(cnt), ones(7'(p), 6));
    end
    // R3..R6: exhaustive sweep
    for (int p = 0; p < 128; p++) begin
      int c6, tot;
      apply(7'(p));
      c6  = ones(7'(p), 6);
      tot = ones(7'(p), 7);
      check("R3 parity", int'(cnt[0]), tot % 2);
      if (p < 64) begin
        check("R4 carries", int'(cnt[2:1]), c6 / 2);
      end else begin
        check("R5 c2", int'(cnt[2]), (c6 >= 3) ? 1 : 0);
        check("R5 c1", int'(cnt[1]),
              (c6 == 1 || c6 == 2 || c6 == 5 || c6 == 6) ? 1 : 0);
      end
      check("R6 total", int'(cnt), tot);
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < WATCHDOG && !done; t++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule